// File: doc/BRIEF.md
# Secure-Context Escalating Watchdog

This block keeps normal-world software from locking a secure execution context out of the processor. Each register access carries a one-bit world attribute. Only secure software can turn the watchdog on, choose its timeout and service it. A fixed prescaler divides the clock into ticks. A 16-bit countdown, reloaded from the timeout register, runs on those ticks while the watchdog is active.

If secure software stops servicing the watchdog, the countdown runs out and the block raises an interrupt meant for the secure world. That interrupt pulls the processor back into the secure context. The countdown then reloads and runs again. If that second period also ends without a service, the block raises a security-violation output and holds it until reset. To service the watchdog, software writes two keys in a row to the service register. A non-secure access never changes any state apart from a sticky access-error flag, and a non-secure read returns zero.

Register map (2-bit address): 0 = control/status, 1 = timeout reload value, 2 = service key, 3 = current count.

Top module: `sw_guard_wdt`

## Requirements
- R1: After reset the state is off and `sec_irq`, `sec_viol` and `acc_err` are 0. A secure read of address 0 returns 0 and a secure read of address 1 returns the DEF_TIMEOUT parameter.
- R2: A secure write with bit 0 set to address 0 arms the watchdog and loads the count from the timeout register. After that, a read of address 0 returns 3: bit 0 is the enable, bits 2:1 hold the state code (0 off, 1 armed, 2 interrupt, 3 violation) and bit 3 is the error flag. Address 1 reads back the last secure write to it. Address 3 returns the count, which drops by one on each tick, and a tick comes every DIV clocks.
- R3: Once the watchdog is enabled, nothing but reset disables it. A secure write of 0 to address 0 leaves bit 0 of the control/status register set.
- R4: A non-secure write changes no register, no state and no key progress. A non-secure read returns 0. Any non-secure access sets `acc_err`, which is visible as bit 3 of address 0 and stays set until reset.
- R5: With timeout value T, `sec_irq` rises exactly (T+1)·DIV clock edges after the enabling write edge, and the state code becomes 2.
- R6: Once in the interrupt state, the count reloads. If no service arrives within a further (T+1)·DIV edges, `sec_viol` rises, `sec_irq` falls and the state code becomes 3.
- R7: A secure write of 0x5555 to address 2, followed directly by a secure write of 0xAAAA to address 2, services the watchdog. Servicing reloads the count, restarts the prescaler, clears `sec_irq` and returns the state to armed.
- R8: If any other value is written to address 2 between 0x5555 and 0xAAAA, the sequence fails and the block is not serviced.
- R9: In the violation state, a complete key sequence changes nothing, and `sec_viol` stays high until reset.
- R10: When a service completes on the same edge as an expiry, the service wins. This holds for both the first expiry and the second expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| secure | input | 1 | World attribute of the access: 1 secure, 0 non-secure |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational, 0 unless a secure read |
| sec_irq | output | 1 | Secure-world interrupt, high in the interrupt state |
| sec_viol | output | 1 | Security-violation output, high in the violation state |
| acc_err | output | 1 | Sticky flag for non-secure access attempts |

## Verification
A service and a countdown expiry can both fall on the same clock edge. This can happen at the first stage, where it competes with raising the interrupt, and again at the second stage, where it competes with raising the violation. The bench counts edges from the enabling write and places the second key write so that it lands on the exact expiry edge of each stage. It then expects both outputs low, the armed code, and a fully reloaded count.

// File: rtl/sw_guard_wdt.sv
module sw_guard_wdt #(
  parameter int          DIV         = 4,
  parameter logic [15:0] DEF_TIMEOUT = 16'h0100,
  parameter logic [15:0] KEY_A       = 16'h5555,
  parameter logic [15:0] KEY_B       = 16'hAAAA
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic        secure,
  input  logic [1:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        sec_irq,
  output logic        sec_viol,
  output logic        acc_err
);
  localparam int            PW    = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PLAST = PW'(DIV - 1);
  localparam logic [1:0]    A_CTRL = 2'd0, A_TMO = 2'd1, A_SVC = 2'd2, A_CNT = 2'd3;

  typedef enum logic [1:0] {S_OFF = 2'd0, S_ARM = 2'd1, S_IRQ = 2'd2, S_VIOL = 2'd3} st_t;

  st_t           st;
  logic [15:0]   tmo, cnt;
  logic [PW-1:0] pc;
  logic          key1, err;

  logic s_wr, running, tick, expire, go, svc_wr, kick;
  assign s_wr    = wr_en & secure;
  assign running = (st == S_ARM) || (st == S_IRQ);
  assign tick    = running && (pc == PLAST);
  assign expire  = tick && (cnt == 16'd0);
  assign go      = s_wr && (addr == A_CTRL) && wdata[0] && (st == S_OFF);
  assign svc_wr  = s_wr && (addr == A_SVC);
  assign kick    = svc_wr && key1 && (wdata == KEY_B) && running;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_OFF;
      tmo  <= DEF_TIMEOUT;
      cnt  <= '0;
      pc   <= '0;
      key1 <= 1'b0;
      err  <= 1'b0;
    end else begin
      if ((wr_en || rd_en) && !secure) err <= 1'b1;
      if (s_wr && addr == A_TMO) tmo <= wdata;
      if (svc_wr) key1 <= (wdata == KEY_A);
      if (go || kick) begin
        st  <= S_ARM;
        cnt <= tmo;
        pc  <= '0;
      end else if (running) begin
        pc <= tick ? '0 : pc + PW'(1);
        if (expire) begin
          cnt <= tmo;
          st  <= (st == S_ARM) ? S_IRQ : S_VIOL;
        end else if (tick) begin
          cnt <= cnt - 16'd1;
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en && secure) begin
      case (addr)
        A_CTRL:  rdata = {12'd0, err, st, (st != S_OFF)};
        A_TMO:   rdata = tmo;
        A_CNT:   rdata = cnt;
        default: rdata = '0;
      endcase
    end
  end

  assign sec_irq  = (st == S_IRQ);
  assign sec_viol = (st == S_VIOL);
  assign acc_err  = err;

  a_r9_viol_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sec_viol |=> sec_viol);
  a_r3_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_OFF) |=> (st != S_OFF));
  a_r4_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |=> acc_err);
  a_r4_nonsec_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !secure) |=> $stable(tmo));
  a_r6_viol_after_irq: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_viol) |-> $past(sec_irq));
  a_r7_kick_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (st == S_ARM && cnt == $past(tmo)));
endmodule

// File: tb/sim_sw_guard_wdt.sv
module sim_sw_guard_wdt;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, secure = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        sec_irq, sec_viol, acc_err;
  int          n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  sw_guard_wdt #(.DIV(4), .DEF_TIMEOUT(16'h0100)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .secure(secure),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .sec_irq(sec_irq), .sec_viol(sec_viol), .acc_err(acc_err));

  // {write, secure, addr, data, expected read, requirement number}
  localparam logic [39:0] VEC [10] = '{
    {1'b0, 1'b1, 2'd1, 16'h0000, 16'h0100, 4'd1},  // R1 default timeout
    {1'b1, 1'b1, 2'd1, 16'h0030, 16'h0000, 4'd2},
    {1'b0, 1'b1, 2'd1, 16'h0000, 16'h0030, 4'd2},  // R2 readback
    {1'b1, 1'b0, 2'd1, 16'h7777, 16'h0000, 4'd4},
    {1'b0, 1'b1, 2'd1, 16'h0000, 16'h0030, 4'd4},  // R4 write ignored
    {1'b0, 1'b0, 2'd1, 16'h0000, 16'h0000, 4'd4},  // R4 read zero
    {1'b0, 1'b1, 2'd0, 16'h0000, 16'h0008, 4'd4},  // R4 error flag
    {1'b1, 1'b0, 2'd0, 16'h0001, 16'h0000, 4'd4},
    {1'b0, 1'b1, 2'd0, 16'h0000, 16'h0008, 4'd4},  // R4 not enabled
    {1'b0, 1'b1, 2'd2, 16'h0000, 16'h0000, 4'd2}
  };

  task automatic chk(input int req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; secure = s; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; secure = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic s, input logic [1:0] a, output logic [15:0] d);
    rd_en = 1'b1; secure = s; addr = a;
    #1 d = rdata;
    rd_en = 1'b0; secure = 1'b0;
  endtask

  task automatic do_reset();
    wr_en = 1'b0; rd_en = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got hang expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v;
    do_reset();
    // R1 reset state
    chk(1, {13'd0, sec_irq, sec_viol, acc_err}, 16'd0);
    rd(1'b1, 2'd0, v); chk(1, v, 16'h0000);

    for (int i = 0; i < 10; i++) begin
      if (VEC[i][39]) wr(VEC[i][38], VEC[i][37:36], VEC[i][35:20]);
      else begin
        rd(VEC[i][38], VEC[i][37:36], v);
        chk(int'(VEC[i][3:0]), v, VEC[i][19:4]);
      end
    end

    // R2 R5 R3 R6 R9: full escalation, T=3, DIV=4
    do_reset();
    wr(1'b1, 2'd1, 16'd3);
    wr(1'b1, 2'd0, 16'h0001);
    rd(1'b1, 2'd0, v); chk(2, v, 16'h0003);
    rd(1'b1, 2'd3, v); chk(2, v, 16'd3);
    idle(4);
    rd(1'b1, 2'd3, v); chk(2, v, 16'd2);
    idle(11); chk(5, {15'd0, sec_irq}, 16'd0);
    idle(1);  chk(5, {15'd0, sec_irq}, 16'd1);
    rd(1'b1, 2'd0, v); chk(5, v, 16'h0005);
    wr(1'b1, 2'd0, 16'h0000);
    rd(1'b1, 2'd0, v); chk(3, v, 16'h0005);
    idle(14); chk(6, {15'd0, sec_viol}, 16'd0);
    idle(1);  chk(6, {14'd0, sec_irq, sec_viol}, 16'd1);
    wr(1'b1, 2'd2, 16'h5555);
    wr(1'b1, 2'd2, 16'hAAAA);
    rd(1'b1, 2'd0, v); chk(9, v, 16'h0007);
    chk(9, {15'd0, sec_viol}, 16'd1);

    // R4 R8 R7: service paths in the interrupt state
    do_reset();
    wr(1'b1, 2'd1, 16'd3);
    wr(1'b1, 2'd0, 16'h0001);
    idle(16); chk(5, {15'd0, sec_irq}, 16'd1);
    wr(1'b0, 2'd2, 16'h5555);
    wr(1'b0, 2'd2, 16'hAAAA);
    chk(4, {14'd0, sec_irq, acc_err}, 16'd3);
    wr(1'b1, 2'd2, 16'h5555);
    wr(1'b1, 2'd2, 16'h1234);
    wr(1'b1, 2'd2, 16'hAAAA);
    chk(8, {15'd0, sec_irq}, 16'd1);
    wr(1'b1, 2'd2, 16'h5555);
    wr(1'b1, 2'd2, 16'hAAAA);
    chk(7, {15'd0, sec_irq}, 16'd0);
    rd(1'b1, 2'd0, v); chk(7, v, 16'h000B);
    rd(1'b1, 2'd3, v); chk(7, v, 16'd3);
    idle(15); chk(7, {15'd0, sec_irq}, 16'd0);
    idle(1);  chk(7, {15'd0, sec_irq}, 16'd1);

    // R10: service landing on the expiry edge of each stage
    do_reset();
    wr(1'b1, 2'd1, 16'd3);
    wr(1'b1, 2'd0, 16'h0001);
    idle(14);
    wr(1'b1, 2'd2, 16'h5555);
    wr(1'b1, 2'd2, 16'hAAAA);
    chk(10, {14'd0, sec_irq, sec_viol}, 16'd0);
    rd(1'b1, 2'd0, v); chk(10, v, 16'h0003);
    rd(1'b1, 2'd3, v); chk(10, v, 16'd3);
    idle(15); chk(10, {15'd0, sec_irq}, 16'd0);
    idle(1);  chk(10, {15'd0, sec_irq}, 16'd1);
    idle(14);
    wr(1'b1, 2'd2, 16'h5555);
    wr(1'b1, 2'd2, 16'hAAAA);
    chk(10, {14'd0, sec_irq, sec_viol}, 16'd0);
    rd(1'b1, 2'd0, v); chk(10, v, 16'h0003);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule